// File: doc/BRIEF.md
# Transmit Descriptor Interrupt Moderation

This block produces the interrupt causes on the transmit side of a descriptor-ring DMA engine. It tracks the descriptors that are still pending, meaning those between the hardware head pointer and the software tail pointer. It raises a low-water cause when that pending count drops exactly onto a programmable threshold. Software can then keep adding work and is interrupted only when the hardware is close to running dry.

A second source is an absolute delay timer. The first completion of a batch arms it. Later completions do not move it. After a programmed number of ticks it raises the transmit cause. The tick is a single-cycle enable that nominally arrives every 1.024 microseconds.

Both causes are sticky and are cleared by a write-one-to-clear strobe. Two 32-bit control words, one for the threshold and one for the delay, can be written and read back.

Top module: `txirq_moderator`

## Requirements
- R1: The threshold word `ctl_rdata` holds a 7-bit field in bits 31:25. The field resets to zero. All other bits of the word always read as zero.
- R2: The effective threshold equals eight times the threshold field, counted in descriptors.
- R3: The low-water cause (`cause_low`, clear-strobe bit 0) is set when the pending count moves from threshold+1 to exactly threshold. It becomes visible two clock edges after the pointer change.
- R4: No other change of the pending count sets the low-water cause. This covers a jump that skips threshold+1, a step below the threshold and an upward step.
- R5: With a threshold field of zero, the low-water cause is set only when the pending count goes from one to zero.
- R6: The pending count is (tail − head) modulo 2^PTR_W, so it stays correct when the tail has wrapped below the head.
- R7: A completion pulse while the timer is idle loads the 16-bit delay value. The tick that brings the timer to its end sets the transmit cause (`cause_tx`, clear-strobe bit 1), and the timer returns to idle. This happens on the delay-th tick after the load.
- R8: A completion pulse while the timer is running does not reload it.
- R9: A delay value of zero disables the timer. Completions then never set the transmit cause.
- R10: The delay word `dly_rdata` holds the 16-bit delay in bits 15:0. It resets to zero. Bits 31:16 always read zero, whatever was written to them.
- R11: Cause bits stay set until a clear strobe with a one in their bit position. When a clear and a new event meet in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head | input | PTR_W | Hardware head pointer |
| tail | input | PTR_W | Software tail pointer |
| done_pulse | input | 1 | One-cycle descriptor completion |
| tick | input | 1 | One-cycle time-base enable (1.024 µs nominal) |
| ctl_we | input | 1 | Write strobe for the threshold word |
| ctl_wdata | input | 32 | Threshold word write data |
| dly_we | input | 1 | Write strobe for the delay word |
| dly_wdata | input | 32 | Delay word write data |
| clr_we | input | 1 | Cause clear strobe |
| clr_bits | input | 2 | Write-one-to-clear mask (bit 0 low-water, bit 1 transmit) |
| ctl_rdata | output | 32 | Threshold word readback |
| dly_rdata | output | 32 | Delay word readback |
| cause_low | output | 1 | Low-water cause |
| cause_tx | output | 1 | Absolute-delay transmit cause |

## Verification
The bound checker runs on every cycle. It checks that the reserved readback bits stay zero. It checks that every rise of the low-water cause follows an exact threshold+1 to threshold step in the pending count seen at the pointer ports. It checks that every rise of the transmit cause follows a tick, and that set cause bits persist until a matching clear. The bench scenarios are the only place several behaviours show up: the tick count up to expiry, the refusal to reload on later completions, disabling by a zero delay, wrap-around of the pointers, and a clear colliding with a new event.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
  localparam int REG_W      = 32;
  localparam int LWT_LSB    = 25;
  localparam int CAUSE_N    = 2;
  localparam int CAUSE_LOWI = 0;
  localparam int CAUSE_TXI  = 1;

  typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_e;
endpackage

// File: rtl/txirq_lowwater.sv
module txirq_lowwater #(
  parameter int PTR_W = 8,
  parameter int LWT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] tail,
  input  logic [LWT_W-1:0] lwt,
  output logic             hit
);
  localparam int THR_W = LWT_W + 3;
  localparam int CMP_W = ((THR_W > PTR_W) ? THR_W : PTR_W) + 1;

  logic [PTR_W-1:0] cnt_q, prev_q;
  logic [CMP_W-1:0] cur_x, prev_x, thr_x;

  // pending distance, modulo ring size
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else begin
      cnt_q  <= tail - head;
      prev_q <= cnt_q;
    end
  end

  always_comb begin
    cur_x  = {{(CMP_W-PTR_W){1'b0}}, cnt_q};
    prev_x = {{(CMP_W-PTR_W){1'b0}}, prev_q};
    thr_x  = {{(CMP_W-THR_W){1'b0}}, lwt, 3'b000};
    hit    = (cur_x == thr_x) && (prev_x == thr_x + 1'b1);
  end
endmodule

// File: rtl/txirq_abstimer.sv
module txirq_abstimer
  import txirq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_pulse,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  tmr_state_e       st_q;
  logic [DLY_W-1:0] cnt_q;
  logic             dly_zero;

  assign dly_zero = (dly == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      case (st_q)
        TMR_IDLE: begin
          if (done_pulse && !dly_zero) begin
            st_q  <= TMR_RUN;
            cnt_q <= dly;
          end
        end
        default: begin
          if (dly_zero) begin
            st_q <= TMR_IDLE;
          end else if (tick) begin
            if (cnt_q <= 1) begin
              fire <= 1'b1;
              st_q <= TMR_IDLE;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/txirq_regs.sv
module txirq_regs
  import txirq_pkg::*;
#(
  parameter int LWT_W = 7,
  parameter int DLY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [REG_W-1:0]   ctl_wdata,
  input  logic               dly_we,
  input  logic [REG_W-1:0]   dly_wdata,
  input  logic               clr_we,
  input  logic [CAUSE_N-1:0] clr_bits,
  input  logic [CAUSE_N-1:0] set_bits,
  output logic [LWT_W-1:0]   lwt,
  output logic [DLY_W-1:0]   dly,
  output logic [CAUSE_N-1:0] cause,
  output logic [REG_W-1:0]   ctl_rdata,
  output logic [REG_W-1:0]   dly_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lwt <= '0;
      dly <= '0;
    end else begin
      if (ctl_we) lwt <= ctl_wdata[LWT_LSB +: LWT_W];
      if (dly_we) dly <= dly_wdata[DLY_W-1:0];
    end
  end

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (rst) cause[i] <= 1'b0;
      else     cause[i] <= (cause[i] & ~(clr_we & clr_bits[i])) | set_bits[i];
    end
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[LWT_LSB +: LWT_W] = lwt;
    dly_rdata = '0;
    dly_rdata[DLY_W-1:0] = dly;
  end
endmodule

// File: rtl/txirq_moderator.sv
module txirq_moderator
  import txirq_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int LWT_W = 7,
  parameter int DLY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PTR_W-1:0]   head,
  input  logic [PTR_W-1:0]   tail,
  input  logic               done_pulse,
  input  logic               tick,
  input  logic               ctl_we,
  input  logic [REG_W-1:0]   ctl_wdata,
  input  logic               dly_we,
  input  logic [REG_W-1:0]   dly_wdata,
  input  logic               clr_we,
  input  logic [CAUSE_N-1:0] clr_bits,
  output logic [REG_W-1:0]   ctl_rdata,
  output logic [REG_W-1:0]   dly_rdata,
  output logic               cause_low,
  output logic               cause_tx
);
  logic [LWT_W-1:0]   lwt;
  logic [DLY_W-1:0]   dly;
  logic               low_hit, tmr_fire;
  logic [CAUSE_N-1:0] set_bits, cause;

  txirq_lowwater #(.PTR_W(PTR_W), .LWT_W(LWT_W)) u_low (
    .clk(clk), .rst(rst), .head(head), .tail(tail), .lwt(lwt), .hit(low_hit)
  );

  txirq_abstimer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst(rst), .done_pulse(done_pulse), .tick(tick), .dly(dly),
    .fire(tmr_fire)
  );

  always_comb begin
    set_bits = '0;
    set_bits[CAUSE_LOWI] = low_hit;
    set_bits[CAUSE_TXI]  = tmr_fire;
  end

  txirq_regs #(.LWT_W(LWT_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dly_we(dly_we), .dly_wdata(dly_wdata), .clr_we(clr_we),
    .clr_bits(clr_bits), .set_bits(set_bits), .lwt(lwt), .dly(dly),
    .cause(cause), .ctl_rdata(ctl_rdata), .dly_rdata(dly_rdata)
  );

  assign cause_low = cause[CAUSE_LOWI];
  assign cause_tx  = cause[CAUSE_TXI];
endmodule

// File: rtl/txirq_moderator_chk.sv
module txirq_moderator_chk #(
  parameter int PTR_W = 8,
  parameter int LWT_W = 7,
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [PTR_W-1:0] head,
  input logic [PTR_W-1:0] tail,
  input logic             tick,
  input logic             clr_we,
  input logic [1:0]       clr_bits,
  input logic [31:0]      ctl_rdata,
  input logic [31:0]      dly_rdata,
  input logic             cause_low,
  input logic             cause_tx
);
  localparam int CMP_W = ((LWT_W + 3 > PTR_W) ? LWT_W + 3 : PTR_W) + 1;

  logic [PTR_W-1:0] pend;
  logic [CMP_W-1:0] pend_x, thr_x;
  assign pend   = tail - head;
  assign pend_x = {{(CMP_W-PTR_W){1'b0}}, pend};
  assign thr_x  = {{(CMP_W-LWT_W-3){1'b0}}, ctl_rdata[31 -: LWT_W], 3'b000};

  // R10
  dly_resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    dly_rdata[31:DLY_W] == '0);

  // R1
  ctl_resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[31-LWT_W:0] == '0);

  // R3
  low_exact_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cause_low) |-> ($past(pend_x, 2) == $past(thr_x, 1)) &&
                         ($past(pend_x, 3) == $past(thr_x, 1) + 1'b1));

  // R7
  tx_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cause_tx) |-> $past(tick, 2));

  // R11
  low_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_low && !(clr_we && clr_bits[0])) |=> cause_low);

  // R11
  tx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_tx && !(clr_we && clr_bits[1])) |=> cause_tx);
endmodule

bind txirq_moderator txirq_moderator_chk #(
  .PTR_W(PTR_W), .LWT_W(LWT_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst(rst), .head(head), .tail(tail), .tick(tick),
  .clr_we(clr_we), .clr_bits(clr_bits), .ctl_rdata(ctl_rdata),
  .dly_rdata(dly_rdata), .cause_low(cause_low), .cause_tx(cause_tx)
);

// File: tb/txirq_moderator_bench.sv
`timescale 1ns/1ps
module txirq_moderator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  head = '0, tail = '0;
  logic        done_pulse = 1'b0, tick = 1'b0;
  logic        ctl_we = 1'b0, dly_we = 1'b0, clr_we = 1'b0;
  logic [31:0] ctl_wdata = '0, dly_wdata = '0;
  logic [1:0]  clr_bits = '0;
  logic [31:0] ctl_rdata, dly_rdata;
  logic        cause_low, cause_tx;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  txirq_moderator u_txirq_moderator (
    .clk(clk), .rst(rst), .head(head), .tail(tail), .done_pulse(done_pulse),
    .tick(tick), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .dly_we(dly_we),
    .dly_wdata(dly_wdata), .clr_we(clr_we), .clr_bits(clr_bits),
    .ctl_rdata(ctl_rdata), .dly_rdata(dly_rdata), .cause_low(cause_low),
    .cause_tx(cause_tx)
  );

  typedef struct packed {
    logic [6:0] lwt;
    logic [7:0] h0, t0, h1, t1;
    logic       exp_low;
  } vec_t;

  // R3 exact step, R4 non-steps, R5 zero field, R6 wrap, R2 scaling by eight
  localparam vec_t VECS [8] = '{
    '{7'd1, 8'd0,   8'd9,  8'd1,   8'd9,  1'b1},  // R3 9->8
    '{7'd1, 8'd0,   8'd10, 8'd2,   8'd10, 1'b0},  // R4 10->8 jump
    '{7'd1, 8'd1,   8'd9,  8'd2,   8'd9,  1'b0},  // R4 8->7
    '{7'd1, 8'd1,   8'd9,  8'd1,   8'd10, 1'b0},  // R4 8->9 upward
    '{7'd0, 8'd4,   8'd5,  8'd5,   8'd5,  1'b1},  // R5 1->0
    '{7'd2, 8'd250, 8'd11, 8'd251, 8'd11, 1'b1},  // R6 17->16 wrapped
    '{7'd0, 8'd3,   8'd5,  8'd5,   8'd5,  1'b0},  // R5 2->0
    '{7'd3, 8'd100, 8'd125, 8'd101, 8'd125, 1'b1} // R2 25->24
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_bits = 2'b11;
    cyc(1);
    clr_we = 1'b0; clr_bits = 2'b00;
  endtask

  task automatic wr_ctl(input logic [31:0] d);
    ctl_we = 1'b1; ctl_wdata = d; cyc(1); ctl_we = 1'b0;
  endtask

  task automatic wr_dly(input logic [31:0] d);
    dly_we = 1'b1; dly_wdata = d; cyc(1); dly_we = 1'b0;
  endtask

  task automatic do_done();
    done_pulse = 1'b1; cyc(1); done_pulse = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // reset state
    check("R1 reset ctl", ctl_rdata, 32'h0);
    check("R10 reset dly", dly_rdata, 32'h0);
    check("R11 reset low", {31'b0, cause_low}, 32'h0);
    check("R11 reset tx", {31'b0, cause_tx}, 32'h0);

    // readback
    wr_ctl(32'hFFFF_FFFF);
    check("R1 ctl readback", ctl_rdata, 32'hFE00_0000);
    wr_dly(32'hABCD_1234);
    check("R10 dly readback", dly_rdata, 32'h0000_1234);
    wr_dly(32'h0);

    // vector table
    foreach (VECS[k]) begin
      wr_ctl({VECS[k].lwt, 25'h0});
      head = VECS[k].h0; tail = VECS[k].t0;
      cyc(4);
      clear_all();
      cyc(1);
      head = VECS[k].h1; tail = VECS[k].t1;
      cyc(3);
      check($sformatf("R3/R4 vec%0d low", k), {31'b0, cause_low}, {31'b0, VECS[k].exp_low});
    end

    // R11 set wins over clear in the same cycle (field 1, 9->8)
    wr_ctl({7'd1, 25'h0});
    head = 8'd0; tail = 8'd9; cyc(4);
    clear_all(); cyc(1);
    head = 8'd1;            // pointer change before edge 1
    cyc(1);                 // edge 1: count updates
    clr_we = 1'b1; clr_bits = 2'b01;
    cyc(1);                 // edge 2: set and clear together
    clr_we = 1'b0; clr_bits = 2'b00;
    check("R11 set beats clear", {31'b0, cause_low}, 32'h1);
    cyc(3);
    check("R11 sticky", {31'b0, cause_low}, 32'h1);
    clear_all(); cyc(1);
    check("R11 w1c clears", {31'b0, cause_low}, 32'h0);

    // R7 expiry after exactly N ticks
    wr_dly(32'd5);
    clear_all();
    do_done();
    ticks(4); cyc(3);
    check("R7 not before 5th tick", {31'b0, cause_tx}, 32'h0);
    ticks(1); cyc(3);
    check("R7 expiry on 5th tick", {31'b0, cause_tx}, 32'h1);
    clear_all(); cyc(1);
    check("R11 tx cleared", {31'b0, cause_tx}, 32'h0);

    // R8 later completion does not restart
    do_done();
    ticks(3);
    do_done();
    ticks(2); cyc(3);
    check("R8 no reload", {31'b0, cause_tx}, 32'h1);
    clear_all(); cyc(1);

    // R9 zero delay disables
    wr_dly(32'd0);
    do_done();
    ticks(20); cyc(3);
    check("R9 zero delay", {31'b0, cause_tx}, 32'h0);

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule